// File: doc/BRIEF.md
# Crossing-Aligned One-Shot Timing Command Generator

This block fires a single trigger (L1A) or a single broadcast timing command when software asks for it. The strobe does not leave at once. The block waits until its own bunch-crossing counter reaches a crossing number that software has programmed, and only then sends the strobe. The counter is restarted by the orbit-start strobe (BC0) and wraps once per orbit. This lets software place a command at an exact position in the orbit, for example to bring front-end state machines up in step with the beam structure.

The outputs are an extra trigger and command source. Downstream logic ORs them with the received timing channels. A global enable switches the generator off completely, for example during physics running. While it is off, requests are refused, and a request that is still pending is dropped. Only one command is handled at a time. Software builds longer sequences by issuing one request after another and polling the busy and done flags. A target crossing outside the orbit is refused and flagged as an error.

Top module: `bxsync_cmd_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0 and no orbit start is recorded.
- R2: The crossing counter reads 0 in the cycle after a BC0 pulse. Otherwise it rises by one per clock and returns to 0 after ORBIT_LEN-1 (3563 by default).
- R3: A start pulse is accepted when the enable is high, the block is idle and the target is below ORBIT_LEN. In the next cycle busy_o is 1, and done_o and err_o are 0.
- R4: An accepted request produces exactly one strobe, one cycle long, in the cycle in which the counter equals the latched target. With kind_cmd_i=0 the strobe is on l1a_o. With kind_cmd_i=1 it is on cmd_stb_o, and cmd_code_o carries the latched code. cmd_code_o is 0 in every other cycle.
- R5: In the cycle after the strobe, busy_o is 0 and done_o is 1.
- R6: After reset, no strobe is sent until a BC0 has been seen. A request made before that stays pending.
- R7: A start with a target of ORBIT_LEN or more, given while enabled and idle, sets err_o in the next cycle. busy_o stays 0 and no strobe follows.
- R8: While the enable is low, a start pulse changes none of busy_o, done_o or err_o, and no strobe follows.
- R9: A start pulse that arrives while busy is dropped, including in the strobe cycle itself. The pending request keeps its kind, code and target.
- R10: If the enable drops while a request is pending, busy_o is 0 in the next cycle, done_o stays 0 and no strobe is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bc0_i | input | 1 | Orbit-start strobe |
| gen_en_i | input | 1 | Global generator enable |
| start_i | input | 1 | One-cycle request pulse |
| kind_cmd_i | input | 1 | 0 selects L1A, 1 selects broadcast command |
| cmd_code_i | input | CMD_W | Broadcast command code |
| target_bx_i | input | BX_W | Crossing at which to fire |
| l1a_o | output | 1 | One-cycle trigger strobe |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | CMD_W | Code that goes with cmd_stb_o |
| busy_o | output | 1 | Request pending |
| done_o | output | 1 | Last accepted request was sent |
| err_o | output | 1 | Last request was refused as out of range |

## Verification
Two events can land on the same clock. The first is the orbit-start pulse arriving in the very cycle in which the counter matches a target of 3563. The bench provokes this by running a periodic BC0 that always lands on the last crossing. It expects the strobe to come out on that crossing, with the counter restart showing only in the following cycle. The second is a new start pulse given in the strobe cycle itself. The bench expects exactly one strobe, done set and busy clear afterwards, and no further strobe over the next full orbit.

// File: rtl/bxcmd_pkg.sv
package bxcmd_pkg;
   localparam int unsigned DEF_BX_W      = 12;
   localparam int unsigned DEF_ORBIT_LEN = 3564;
   localparam int unsigned DEF_CMD_W     = 4;

   typedef enum logic {
      KIND_L1A = 1'b0,
      KIND_CMD = 1'b1
   } shot_kind_e;
endpackage

// File: rtl/bxcmd_orbit_ctr.sv
module bxcmd_orbit_ctr #(
   parameter int unsigned BX_W      = bxcmd_pkg::DEF_BX_W,
   parameter int unsigned ORBIT_LEN = bxcmd_pkg::DEF_ORBIT_LEN
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            bc0_i,
   output logic [BX_W-1:0] bx_o,
   output logic            seen_o
);
   localparam logic [BX_W-1:0] LAST_BX = BX_W'(ORBIT_LEN - 1);

   logic [BX_W-1:0] cnt_q, cnt_inc;

   generate
      if (ORBIT_LEN == (2 ** BX_W)) begin : g_natural_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end else begin : g_compare_wrap
         assign cnt_inc = (cnt_q == LAST_BX) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         seen_o <= 1'b0;
      end else if (bc0_i) begin
         cnt_q  <= '0;
         seen_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_inc;
      end
   end

   assign bx_o = cnt_q;

   // R2: wrap after the last crossing of the orbit
   assert_orbit_wrap_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bc0_i && cnt_q == LAST_BX) |=> (cnt_q == '0));
   // R2: orbit start restarts the count
   assert_bc0_restart_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      bc0_i |=> (cnt_q == '0 && seen_o));
endmodule

// File: rtl/bxcmd_shot_fsm.sv
module bxcmd_shot_fsm #(
   parameter int unsigned BX_W      = bxcmd_pkg::DEF_BX_W,
   parameter int unsigned ORBIT_LEN = bxcmd_pkg::DEF_ORBIT_LEN,
   parameter int unsigned CMD_W     = bxcmd_pkg::DEF_CMD_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             gen_en_i,
   input  logic             start_i,
   input  logic             kind_cmd_i,
   input  logic [CMD_W-1:0] cmd_code_i,
   input  logic [BX_W-1:0]  target_bx_i,
   input  logic [BX_W-1:0]  bx_i,
   input  logic             seen_i,
   output logic             l1a_o,
   output logic             cmd_stb_o,
   output logic [CMD_W-1:0] cmd_code_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   import bxcmd_pkg::*;

   localparam int unsigned CMP_W = BX_W + 1;

   logic             busy_q, done_q, err_q;
   shot_kind_e       kind_q;
   logic [CMD_W-1:0] code_q;
   logic [BX_W-1:0]  tgt_q;
   logic             take, in_range, accept, reject, fire;

   assign take     = start_i && gen_en_i && !busy_q;
   assign in_range = CMP_W'(target_bx_i) < CMP_W'(ORBIT_LEN);
   assign accept   = take && in_range;
   assign reject   = take && !in_range;
   assign fire     = busy_q && gen_en_i && seen_i && (bx_i == tgt_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         kind_q <= KIND_L1A;
         code_q <= '0;
         tgt_q  <= '0;
      end else if (busy_q && !gen_en_i) begin
         busy_q <= 1'b0;
      end else if (fire) begin
         busy_q <= 1'b0;
         done_q <= 1'b1;
      end else if (accept) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         kind_q <= shot_kind_e'(kind_cmd_i);
         code_q <= cmd_code_i;
         tgt_q  <= target_bx_i;
      end else if (reject) begin
         done_q <= 1'b0;
         err_q  <= 1'b1;
      end
   end

   assign l1a_o      = fire && (kind_q == KIND_L1A);
   assign cmd_stb_o  = fire && (kind_q == KIND_CMD);
   assign cmd_code_o = cmd_stb_o ? code_q : '0;
   assign busy_o     = busy_q;
   assign done_o     = done_q;
   assign err_o      = err_q;

   // R4: a strobe lasts one cycle only
   assert_single_strobe_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l1a_o || cmd_stb_o) |=> !(l1a_o || cmd_stb_o));
   // R5: strobe retires the request
   assert_strobe_done_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l1a_o || cmd_stb_o) |=> (done_o && !busy_o));
   // R6: never fire before an orbit start was seen
   assert_needs_orbit_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l1a_o || cmd_stb_o) |-> seen_i);
   // R7: a refused request never makes the block busy
   assert_reject_idle_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> !busy_o);
   // R8: a disabled generator stays idle
   assert_disabled_idle_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gen_en_i && !busy_o) |=> !busy_o);
   // R10: busy ends without a strobe only through the enable
   assert_cancel_cause_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(busy_o) && !$past(l1a_o || cmd_stb_o)) |-> !$past(gen_en_i));
endmodule

// File: rtl/bxsync_cmd_gen.sv
module bxsync_cmd_gen #(
   parameter int unsigned BX_W      = bxcmd_pkg::DEF_BX_W,
   parameter int unsigned ORBIT_LEN = bxcmd_pkg::DEF_ORBIT_LEN,
   parameter int unsigned CMD_W     = bxcmd_pkg::DEF_CMD_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bc0_i,
   input  logic             gen_en_i,
   input  logic             start_i,
   input  logic             kind_cmd_i,
   input  logic [CMD_W-1:0] cmd_code_i,
   input  logic [BX_W-1:0]  target_bx_i,
   output logic             l1a_o,
   output logic             cmd_stb_o,
   output logic [CMD_W-1:0] cmd_code_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   generate
      if (ORBIT_LEN < 2 || ORBIT_LEN > (2 ** BX_W)) begin : g_bad_orbit
         $error("ORBIT_LEN must lie in 2 .. 2**BX_W");
      end
      if (CMD_W < 1) begin : g_bad_cmd
         $error("CMD_W must be at least 1");
      end
   endgenerate

   logic [BX_W-1:0] bx;
   logic            seen;

   bxcmd_orbit_ctr #(
      .BX_W(BX_W), .ORBIT_LEN(ORBIT_LEN)
   ) u_orbit (
      .clk_i(clk_i), .rst_ni(rst_ni), .bc0_i(bc0_i),
      .bx_o(bx), .seen_o(seen)
   );

   bxcmd_shot_fsm #(
      .BX_W(BX_W), .ORBIT_LEN(ORBIT_LEN), .CMD_W(CMD_W)
   ) u_shot (
      .clk_i(clk_i), .rst_ni(rst_ni), .gen_en_i(gen_en_i),
      .start_i(start_i), .kind_cmd_i(kind_cmd_i), .cmd_code_i(cmd_code_i),
      .target_bx_i(target_bx_i), .bx_i(bx), .seen_i(seen),
      .l1a_o(l1a_o), .cmd_stb_o(cmd_stb_o), .cmd_code_o(cmd_code_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );
endmodule

// File: tb/test_bxsync_cmd_gen.sv
module test_bxsync_cmd_gen;
   localparam int BX_W = 12;
   localparam int ORB  = 3564;
   localparam int CW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bc0 = 1'b0;
   logic          en = 1'b1;
   logic          start = 1'b0;
   logic          kind = 1'b0;
   logic [CW-1:0] code = '0;
   logic [BX_W-1:0] tgt = '0;
   logic          l1a, cstb, busy, done, err;
   logic [CW-1:0] ocode;

   int  nvec = 0;
   int  nbad = 0;
   int  mbx = 0;
   int  gcnt = 0;
   bit  bc0_auto = 1'b0;

   always #4 clk = ~clk;

   bxsync_cmd_gen #(.BX_W(BX_W), .ORBIT_LEN(ORB), .CMD_W(CW)) i_bxsync_cmd_gen (
      .clk_i(clk), .rst_ni(rst_n), .bc0_i(bc0), .gen_en_i(en), .start_i(start),
      .kind_cmd_i(kind), .cmd_code_i(code), .target_bx_i(tgt),
      .l1a_o(l1a), .cmd_stb_o(cstb), .cmd_code_o(ocode),
      .busy_o(busy), .done_o(done), .err_o(err)
   );

   // reference crossing number from the R2 rule
   always @(posedge clk) begin
      if (!rst_n)   mbx <= 0;
      else if (bc0) mbx <= 0;
      else          mbx <= (mbx == ORB - 1) ? 0 : mbx + 1;
   end

   // periodic orbit start, one pulse every ORB cycles
   always @(negedge clk) begin
      gcnt <= (gcnt == ORB - 1) ? 0 : gcnt + 1;
      bc0  <= bc0_auto && (gcnt == ORB - 1);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic quiet(input int n, input string req);
      int hits = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (l1a || cstb) hits++;
      end
      chk(hits == 0, req, hits, 0);
   endtask

   task automatic pulse_start(input bit k, input int c, input int t);
      kind = k; code = CW'(c); tgt = BX_W'(t); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // one request, checked through to done; poke restarts in the strobe cycle
   task automatic run_shot(input bit k, input int c, input int t, input bit poke, input string req);
      int waited = 0;
      pulse_start(k, c, t);
      chk(busy == 1'b1 && done == 1'b0 && err == 1'b0, "R3 accept", {busy, done, err}, 3'b100);
      while (!(l1a || cstb) && waited < 2 * ORB + 4) begin
         @(negedge clk);
         waited++;
      end
      chk(l1a || cstb, {req, " strobe seen"}, l1a || cstb, 1);
      chk(mbx == t, {req, " strobe crossing"}, mbx, t);
      chk(l1a == !k && cstb == k, "R4 kind", {l1a, cstb}, {!k, k});
      chk(ocode == (k ? CW'(c) : '0), "R4 code", ocode, k ? c : 0);
      if (poke) begin
         kind = 1'b0; tgt = BX_W'(7); start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk(!l1a && !cstb, "R4 one cycle", {l1a, cstb}, 0);
      chk(done == 1'b1 && busy == 1'b0, "R5 retire", {busy, done}, 2'b01);
      if (poke) begin
         quiet(ORB + 8, "R9 start in strobe cycle dropped");
         chk(busy == 1'b0 && done == 1'b1, "R9 state kept", {busy, done}, 2'b01);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk({l1a, cstb, ocode, busy, done, err} == '0, "R1 in reset", {l1a, cstb, busy, done, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({l1a, cstb, ocode, busy, done, err} == '0, "R1 after reset", {l1a, cstb, busy, done, err}, 0);
   endtask

   task automatic t_no_orbit();
      pulse_start(1'b0, 0, 5);
      chk(busy == 1'b1, "R6 pending", busy, 1);
      quiet(ORB + 500, "R6 no strobe before BC0");
      chk(busy == 1'b1, "R6 still pending", busy, 1);
      bc0_auto = 1'b1;
      while (!(l1a || cstb)) @(negedge clk);
      chk(mbx == 5, "R6 first match after BC0", mbx, 5);
      chk(l1a == 1'b1, "R4 L1A strobe", l1a, 1);
      @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, "R5 after first shot", {busy, done}, 2'b01);
   endtask

   task automatic t_range();
      pulse_start(1'b1, 3, ORB);
      chk(err == 1'b1 && busy == 1'b0 && done == 1'b0, "R7 reject 3564", {busy, done, err}, 3'b001);
      pulse_start(1'b0, 0, 4095);
      chk(err == 1'b1 && busy == 1'b0, "R7 reject 4095", {busy, err}, 2'b01);
      quiet(ORB + 4, "R7 nothing emitted");
      run_shot(1'b1, 2, 100, 1'b0, "R3 error cleared then shot");
   endtask

   task automatic t_disabled();
      en = 1'b0;
      pulse_start(1'b0, 0, 10);
      chk(busy == 1'b0 && done == 1'b1 && err == 1'b0, "R8 start ignored", {busy, done, err}, 3'b010);
      pulse_start(1'b0, 0, ORB + 1);
      chk(err == 1'b0, "R8 bad target ignored", err, 0);
      quiet(ORB + 4, "R8 no strobe while disabled");
      en = 1'b1;
   endtask

   task automatic t_busy_drop();
      int waited = 0;
      pulse_start(1'b0, 0, 2000);
      pulse_start(1'b1, 9, 1000);
      chk(busy == 1'b1, "R9 still busy", busy, 1);
      while (!(l1a || cstb) && waited < 2 * ORB) begin
         @(negedge clk);
         waited++;
      end
      chk(mbx == 2000 && l1a == 1'b1 && cstb == 1'b0, "R9 first request kept", mbx, 2000);
      quiet(ORB + 4, "R9 no second strobe");
   endtask

   task automatic t_cancel();
      pulse_start(1'b1, 6, (mbx + 1500) % ORB);
      chk(busy == 1'b1, "R10 pending", busy, 1);
      en = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R10 cancelled", {busy, done}, 2'b00);
      en = 1'b1;
      quiet(ORB + 4, "R10 no strobe after cancel");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      t_reset();
      t_no_orbit();
      run_shot(1'b1, 4'hA, 0, 1'b0, "R2 first crossing");
      run_shot(1'b0, 0, 3563, 1'b1, "R2 last crossing with BC0");
      run_shot(1'b1, 4'hF, 1234, 1'b0, "R4 mid orbit command");
      t_range();
      t_disabled();
      t_busy_drop();
      t_cancel();
      run_shot(1'b1, 1, 42, 1'b0, "R3 recovered after cancel");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule